// File: doc/BRIEF.md
# Combinational Add/Subtract and Logic Unit with Condition Flags

This block is a purely combinational integer datapath stage. It takes two operands and a three-bit operation code and returns one result word together with four condition flags: carry-out, signed overflow, zero and negative. One adder serves both addition and subtraction. For a subtract, the second operand is inverted bit by bit and the adder's carry-in is raised, both from the same control. Inside the adder, carries are formed by lookahead within fixed-size bit groups and are passed in a chain from one group to the next.

The bitwise operations (AND, OR, XOR, NOR) are formed in parallel across the word. A set-on-less-than operation gives a signed comparison of the two operands as a zero-extended one-bit result. The comparison takes the sign of the difference and corrects it with the subtract overflow term, so it is right even when the difference itself overflows. A surrounding pipeline uses the block as its execute-stage arithmetic unit and registers its outputs as it needs.

Top module: `alu_core`

## Requirements
- R1: With op code 000 (add), the result is (A + B) modulo 2^W and carry-out is the carry leaving the most significant bit, which is the unsigned overflow indication.
- R2: With op code 001 (subtract), the result is (A - B) modulo 2^W, formed as A + ~B + 1; carry-out is the adder's carry leaving the top bit, so it is 1 exactly when A >= B as unsigned numbers.
- R3: On add, the overflow flag is 1 exactly when both operands have sign bit 0 and the result has sign bit 1, or when both have sign bit 1 and the result has sign bit 0; operands of differing sign never overflow.
- R4: On subtract, the overflow flag is 1 exactly when A is non-negative, B is negative and the result is negative, or when A is negative, B is non-negative and the result is non-negative; operands of equal sign never overflow.
- R5: Op codes 010, 011, 100 and 101 give bitwise A AND B, A OR B, A XOR B and NOT(A OR B), in that order.
- R6: For every op code other than 000 and 001, both carry-out and overflow are 0.
- R7: The zero flag is 1 exactly when every bit of the result is 0, for every op code.
- R8: The negative flag equals the most significant result bit, for every op code.
- R9: Op code 110 (set-on-less-than) gives 1 in bit 0 when A < B as two's-complement numbers and 0 otherwise, with all higher bits 0, including the cases where A - B overflows.
- R10: Op code 111 is unused and gives an all-zero result, so the zero flag is 1 and the other three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand (subtrahend for subtract and set-on-less-than) |
| op_i | input | 3 | Operation code |
| result_o | output | W | Selected result word |
| carry_o | output | 1 | Carry leaving the top adder bit on add or subtract, else 0 |
| ovf_o | output | 1 | Two's-complement overflow on add or subtract, else 0 |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Most significant bit of the result |

## Verification
The block holds no state, so any fault in a group carry, in the inversion control or in the flag logic shows on the ports at the same instant as the operands that expose it. A broken lookahead term corrupts the sum only for the operand pairs whose carry runs through that term. For this reason the operand space of a four-bit build is swept completely for all eight op codes. At the full width, directed vectors cover the carry chain across every group boundary and the overflow corners of subtraction, where a set-on-less-than that ignores the overflow correction gives the wrong answer at once.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_NOR  = 3'b101,
        OP_SLT  = 3'b110,
        OP_RSVD = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic neg;
    } alu_flags_t;

    // True for the two codes whose carry and overflow are reported.
    function automatic logic op_reports_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    // The shared adder subtracts for both subtract and compare.
    function automatic logic op_needs_subtract(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

    // True for the four bitwise codes.
    function automatic logic op_is_bitwise(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    endfunction

endpackage

// File: rtl/alu_cla_group.sv
module alu_cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_i,
    output logic [GW-1:0] sum_o,
    output logic          grp_gen_o,
    output logic          grp_prop_o
);

    logic [GW-1:0] gen;
    logic [GW-1:0] prop;
    logic [GW:0]   carry;

    assign gen  = a_i & b_i;
    assign prop = a_i ^ b_i;

    // Each carry is a flat sum of products: a generate at bit j that
    // survives every propagate above it, or the group carry-in.
    always_comb begin
        logic cy;
        logic prod;
        carry[0] = cin_i;
        for (int k = 1; k <= GW; k++) begin
            cy = 1'b0;
            for (int j = 0; j < k; j++) begin
                prod = gen[j];
                for (int m = j + 1; m < k; m++) begin
                    prod = prod & prop[m];
                end
                cy = cy | prod;
            end
            prod = cin_i;
            for (int m = 0; m < k; m++) begin
                prod = prod & prop[m];
            end
            carry[k] = cy | prod;
        end
    end

    // Group generate excludes the carry-in; group propagate is all-propagate.
    always_comb begin
        logic gg;
        logic prod;
        gg = 1'b0;
        for (int j = 0; j < GW; j++) begin
            prod = gen[j];
            for (int m = j + 1; m < GW; m++) begin
                prod = prod & prop[m];
            end
            gg = gg | prod;
        end
        grp_gen_o = gg;
    end

    assign grp_prop_o = &prop;
    assign sum_o      = prop ^ carry[GW-1:0];

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W   = 32,
    parameter int GRP = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    localparam int NGRP = W / GRP;

    logic [W-1:0]  b_eff;
    logic [NGRP:0] grp_c;
    logic [NGRP-1:0] grp_g;
    logic [NGRP-1:0] grp_p;

    // One control inverts B and feeds the carry-in.
    assign b_eff    = b_i ^ {W{sub_i}};
    assign grp_c[0] = sub_i;

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        alu_cla_group #(.GW(GRP)) u_grp (
            .a_i       (a_i[gi*GRP +: GRP]),
            .b_i       (b_eff[gi*GRP +: GRP]),
            .cin_i     (grp_c[gi]),
            .sum_o     (sum_o[gi*GRP +: GRP]),
            .grp_gen_o (grp_g[gi]),
            .grp_prop_o(grp_p[gi])
        );
        assign grp_c[gi+1] = grp_g[gi] | (grp_p[gi] & grp_c[gi]);
    end

    assign cout_o = grp_c[NGRP];

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] out_o
);

    logic [W-1:0] and_w;
    logic [W-1:0] or_w;
    logic [W-1:0] xor_w;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_w[i] = a_i[i] & b_i[i];
        assign or_w[i]  = a_i[i] | b_i[i];
        assign xor_w[i] = a_i[i] ^ b_i[i];
    end

    always_comb begin
        unique case (op_i)
            OP_AND:  out_o = and_w;
            OP_OR:   out_o = or_w;
            OP_XOR:  out_o = xor_w;
            OP_NOR:  out_o = ~or_w;
            default: out_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic         a_msb_i,
    input  logic         b_msb_i,
    input  logic         sum_msb_i,
    input  logic         cout_i,
    input  logic [W-1:0] result_i,
    output logic         less_o,
    output alu_flags_t   flags_o
);

    logic ovf_add;
    logic ovf_sub;
    logic report;

    // Same-sign operands whose sum flips sign.
    assign ovf_add = (~a_msb_i & ~b_msb_i &  sum_msb_i) |
                     ( a_msb_i &  b_msb_i & ~sum_msb_i);

    // Opposite-sign operands whose difference takes B's sign.
    assign ovf_sub = (~a_msb_i &  b_msb_i &  sum_msb_i) |
                     ( a_msb_i & ~b_msb_i & ~sum_msb_i);

    // Sign of A - B corrected by the subtract overflow.
    assign less_o = sum_msb_i ^ ovf_sub;

    assign report = op_reports_arith(op_i);

    always_comb begin
        flags_o.carry = report & cout_i;
        flags_o.ovf   = report & ((op_i == OP_SUB) ? ovf_sub : ovf_add);
        flags_o.zero  = ~(|result_i);
        flags_o.neg   = result_i[W-1];
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int GRP = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   op_i,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         zero_o,
    output logic         neg_o
);

    alu_op_e    op;
    logic       sub_mode;
    logic [W-1:0] sum;
    logic       cout;
    logic [W-1:0] logic_out;
    logic       less;
    logic [W-1:0] result;
    alu_flags_t flags;

    assign op       = alu_op_e'(op_i);
    assign sub_mode = op_needs_subtract(op);

    alu_addsub #(.W(W), .GRP(GRP)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (sub_mode),
        .sum_o (sum),
        .cout_o(cout)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a_i  (a_i),
        .b_i  (b_i),
        .op_i (op),
        .out_o(logic_out)
    );

    always_comb begin
        if (op_reports_arith(op)) begin
            result = sum;
        end else if (op_is_bitwise(op)) begin
            result = logic_out;
        end else if (op == OP_SLT) begin
            result = {{(W-1){1'b0}}, less};
        end else begin
            result = '0;
        end
    end

    alu_flag_gen #(.W(W)) u_flags (
        .op_i     (op),
        .a_msb_i  (a_i[W-1]),
        .b_msb_i  (b_i[W-1]),
        .sum_msb_i(sum[W-1]),
        .cout_i   (cout),
        .result_i (result),
        .less_o   (less),
        .flags_o  (flags)
    );

    assign result_o = result;
    assign carry_o  = flags.carry;
    assign ovf_o    = flags.ovf;
    assign zero_o   = flags.zero;
    assign neg_o    = flags.neg;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] result_o,
    input logic         carry_o,
    input logic         ovf_o,
    input logic         zero_o,
    input logic         neg_o
);

    logic [W:0] ref_add;
    logic [W:0] ref_sub;
    logic       lt_ref;

    assign ref_add = {1'b0, a_i} + {1'b0, b_i};
    assign ref_sub = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
    assign lt_ref  = $signed(a_i) < $signed(b_i);

    always_comb begin
        if (op_i == 3'b000) begin
            AST_ADD_SUM: assert ({carry_o, result_o} == ref_add) else $error("add mismatch"); // R1
            AST_NO_OVERFLOW: assert ((a_i[W-1] != b_i[W-1]) ? !ovf_o : 1'b1) else $error("add ovf on mixed signs"); // R3
        end
        if (op_i == 3'b001) begin
            AST_SUB_DIFF: assert ({carry_o, result_o} == ref_sub) else $error("sub mismatch"); // R2
            AST_SUB_SAME_SIGN: assert ((a_i[W-1] == b_i[W-1]) ? !ovf_o : 1'b1) else $error("sub ovf on equal signs"); // R4
        end
        if (op_i[2:1] != 2'b00) begin
            AST_FLAGS_CLEAR: assert (!carry_o && !ovf_o) else $error("carry/ovf on non-arith op"); // R6
        end
        if (op_i == 3'b110) begin
            AST_SLT_VALUE: assert (result_o == {{(W-1){1'b0}}, lt_ref}) else $error("slt mismatch"); // R9
        end
        if (op_i == 3'b111) begin
            AST_UNUSED_ZERO: assert (result_o == '0 && zero_o) else $error("unused code nonzero"); // R10
        end
        AST_NEG_SIGN: assert (neg_o == result_o[W-1]) else $error("neg flag mismatch"); // R8
        AST_ZERO_FLAG: assert (zero_o == (result_o == '0)) else $error("zero flag mismatch"); // R7
    end

endmodule

bind alu_core alu_core_chk #(.W(W)) u_alu_core_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_i),
    .result_o(result_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .zero_o  (zero_o),
    .neg_o   (neg_o)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NW-1:0] a4, b4, r4;
    logic [2:0]    op4;
    logic          c4, v4, z4, n4;

    logic [WW-1:0] a32, b32, r32;
    logic [2:0]    op32;
    logic          c32, v32, z32, n32;

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 1'b0;

    alu_core #(.W(NW), .GRP(4)) u_alu_core (
        .a_i(a4), .b_i(b4), .op_i(op4),
        .result_o(r4), .carry_o(c4), .ovf_o(v4), .zero_o(z4), .neg_o(n4)
    );

    alu_core #(.W(WW), .GRP(4)) u_alu_core_w32 (
        .a_i(a32), .b_i(b32), .op_i(op32),
        .result_o(r32), .carry_o(c32), .ovf_o(v32), .zero_o(z32), .neg_o(n32)
    );

    // Arithmetic model of the requirements for width w.
    task automatic model(input int w, input logic [2:0] op,
                         input longint unsigned a, input longint unsigned b,
                         output longint unsigned r, output bit c, output bit v);
        longint unsigned mask, s;
        longint sa, sb, sr, smax, smin;
        mask = (longint'(1) << w) - 1;
        sa = a[w-1] ? longint'(a) - (longint'(1) << w) : longint'(a);
        sb = b[w-1] ? longint'(b) - (longint'(1) << w) : longint'(b);
        smax = (longint'(1) << (w-1)) - 1;
        smin = -(longint'(1) << (w-1));
        r = 0; c = 0; v = 0;
        case (op)
            3'b000: begin
                s = a + b; r = s & mask; c = s[w];
                sr = sa + sb; v = (sr > smax) || (sr < smin);
            end
            3'b001: begin
                s = a + ((~b) & mask) + 1; r = s & mask; c = s[w];
                sr = sa - sb; v = (sr > smax) || (sr < smin);
            end
            3'b010: r = a & b;
            3'b011: r = a | b;
            3'b100: r = a ^ b;
            3'b101: r = (~(a | b)) & mask;
            3'b110: r = (sa < sb) ? 1 : 0;
            default: r = 0;
        endcase
    endtask

    task automatic judge(input int w, input logic [2:0] op,
                         input longint unsigned a, input longint unsigned b,
                         input longint unsigned ra, input bit ca, input bit va,
                         input bit za, input bit na);
        longint unsigned re;
        bit ce, ve, ze, ne, bad;
        string rtag, ctag, vtag;
        model(w, op, a, b, re, ce, ve);
        ze = (re == 0);
        ne = re[w-1];
        case (op)
            3'b000:  begin rtag = "R1";  ctag = "R1"; vtag = "R3"; end
            3'b001:  begin rtag = "R2";  ctag = "R2"; vtag = "R4"; end
            3'b110:  begin rtag = "R9";  ctag = "R6"; vtag = "R6"; end
            3'b111:  begin rtag = "R10"; ctag = "R6"; vtag = "R6"; end
            default: begin rtag = "R5";  ctag = "R6"; vtag = "R6"; end
        endcase
        bad = 0;
        vectors++;
        if (ra != re) begin
            bad = 1;
            $display("FAIL %s result w=%0d op=%0d a=%h b=%h: got %h exp %h", rtag, w, op, a, b, ra, re);
        end
        if (ca != ce) begin
            bad = 1;
            $display("FAIL %s carry w=%0d op=%0d a=%h b=%h: got %0d exp %0d", ctag, w, op, a, b, ca, ce);
        end
        if (va != ve) begin
            bad = 1;
            $display("FAIL %s ovf w=%0d op=%0d a=%h b=%h: got %0d exp %0d", vtag, w, op, a, b, va, ve);
        end
        if (za != ze) begin
            bad = 1;
            $display("FAIL R7 zero w=%0d op=%0d a=%h b=%h: got %0d exp %0d", w, op, a, b, za, ze);
        end
        if (na != ne) begin
            bad = 1;
            $display("FAIL R8 neg w=%0d op=%0d a=%h b=%h: got %0d exp %0d", w, op, a, b, na, ne);
        end
        if (bad) fails++;
    endtask

    task automatic apply4(input logic [2:0] op, input logic [NW-1:0] a, input logic [NW-1:0] b);
        @(posedge clk);
        op4 = op; a4 = a; b4 = b;
        @(negedge clk);
        judge(NW, op, a, b, r4, c4, v4, z4, n4);
    endtask

    task automatic apply32(input logic [2:0] op, input logic [WW-1:0] a, input logic [WW-1:0] b);
        @(posedge clk);
        op32 = op; a32 = a; b32 = b;
        @(negedge clk);
        judge(WW, op, a, b, r32, c32, v32, z32, n32);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        a4 = '0; b4 = '0; op4 = 3'b000;
        a32 = '0; b32 = '0; op32 = 3'b000;

        // All-zero operands on add: zero result, R7 zero flag set.
        apply4(3'b000, 4'h0, 4'h0);
        apply32(3'b000, 32'h0, 32'h0);

        // Exhaustive sweep of the narrow build: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10.
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    apply4(3'(op), 4'(a), 4'(b));
                end
            end
        end

        // Wide build: carry across every group boundary (R1).
        apply32(3'b000, 32'hFFFF_FFFF, 32'h0000_0001);
        apply32(3'b000, 32'h0FFF_FFFF, 32'h0000_0001);
        apply32(3'b000, 32'h7FFF_FFFF, 32'h0000_0001);   // R3 overflow
        apply32(3'b000, 32'h8000_0000, 32'h8000_0000);   // R3 overflow, R1 carry
        apply32(3'b000, 32'h8000_0000, 32'h7FFF_FFFF);   // R3 mixed signs
        // Subtract corners (R2, R4).
        apply32(3'b001, 32'h8000_0000, 32'h0000_0001);
        apply32(3'b001, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply32(3'b001, 32'h1234_5678, 32'h1234_5678);
        apply32(3'b001, 32'h0000_0000, 32'h0000_0001);
        // Compare under overflow (R9).
        apply32(3'b110, 32'h8000_0000, 32'h0000_0001);
        apply32(3'b110, 32'h7FFF_FFFF, 32'h8000_0000);
        apply32(3'b110, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
        apply32(3'b110, 32'h0000_0005, 32'h0000_0005);
        // Bitwise and unused codes (R5, R6, R10).
        apply32(3'b010, 32'hF0F0_A5A5, 32'hFF00_0FF0);
        apply32(3'b011, 32'hF0F0_A5A5, 32'h0F0F_0000);
        apply32(3'b100, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        apply32(3'b101, 32'h0000_0000, 32'h0000_0000);
        apply32(3'b111, 32'hFFFF_FFFF, 32'h1234_5678);
        for (int k = 0; k < 32; k++) begin
            apply32(3'b000, 32'hFFFF_FFFF >> k, 32'h1 << (31 - k));  // R1 carry chain
            apply32(3'b001, 32'h1 << k, 32'hFFFF_FFFF);              // R2 R4
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            summary();
            $finish;
        end
    end

endmodule